// File: doc/BRIEF.md
# Random Generator Event Flags and Interrupt Controller

This block keeps the three event flags of a true random number generator (data ready, seed error, clock error) and drives one interrupt line from them. The seed-error and clock-error events arrive as single-cycle pulses from the generator core. The data-ready event comes from an internal pacing machine. That machine models how long the core takes to fill a group of four 32-bit output words. It then holds the group until software has drained it through four data-register reads. Each flag has its own clear rule. Software reads the flags as a 3-bit status word and clears the error flags by writing zeros to it.

The pacing machine has three states. `PS_IDLE` is entered from reset, and from any state whenever the generator enable is sampled low. `PS_FILL` counts toward the fill interval. `PS_FULL` holds the data-ready flag. It has these transitions:
- IDLE→FILL when enabled.
- FILL→FULL when the count reaches the interval.
- FULL→FILL on the fourth read.

The fill interval is picked by a configuration select and a limiting-stage select. Each error flag is a two-state machine, `FL_CLEAR` and `FL_SET`. It has these transitions:
- CLEAR→SET on its event.
- SET→CLEAR on its clear condition, only when no event arrives in the same cycle.

Top module: `rng_irq_status`

## Requirements
- R1: The status word has bit 0 for data ready, bit 1 for seed error and bit 2 for clock error. After reset the status word is 0 and the interrupt is low.
- R2: A pulse on `seed_err_evt` or `clk_err_evt` sets its status bit at the next clock edge.
- R3: `irq` is high exactly when `gen_en` and `irq_en` are both high and at least one status bit is set. It is low whenever `gen_en` is low.
- R4: Status writes never change bit 0. While bit 0 is set, it clears at the edge that samples the fourth `rd_stb` pulse of the group. `rd_stb` pulses seen while bit 0 is clear are ignored.
- R5: A status write (`wr_en` high) with `wr_data[1]` = 0 clears the seed error, and one with `wr_data[2]` = 0 clears the clock error. A write with a 1 in either bit leaves that flag as it was.
- R6: The seed error also clears at the edge where `cond_rst` is sampled 0 after being sampled 1 at the previous edge. Raising `cond_rst` alone clears nothing.
- R7: A 1-then-0 sequence on `cond_rst` does not clear the clock error.
- R8: When an error event and a clear condition for the same flag occur in one cycle, the flag ends up set.
- R9: The fill interval depends on `cfg_b` and `cond_lim`:
  - `cfg_b`=0, `cond_lim`=0: 256 cycles
  - `cfg_b`=0, `cond_lim`=1: 412 cycles
  - `cfg_b`=1, `cond_lim`=0: 32 cycles
  - `cfg_b`=1, `cond_lim`=1: 206 cycles

  After enable, bit 0 sets at the (interval+1)-th edge counting from the first edge that samples `gen_en` high. Each later group sets bit 0 an interval of edges after the edge that took the fourth read.
- R10: Sampling `gen_en` low returns the pacing machine to idle and clears bit 0. Re-enabling restarts the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator enable |
| irq_en | input | 1 | Global interrupt enable |
| cfg_b | input | 1 | Configuration select (0 = A, 1 = B) |
| cond_lim | input | 1 | Limiting stage (0 = noise source, 1 = conditioning) |
| cond_rst | input | 1 | Conditioning-reset control bit level |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 3 | Status write value |
| rd_stb | input | 1 | Data register read strobe |
| seed_err_evt | input | 1 | Seed error event pulse |
| clk_err_evt | input | 1 | Clock error event pulse |
| status | output | 3 | Flags {clock error, seed error, data ready} |
| irq | output | 1 | Interrupt request |

## Verification
A flag can be set and cleared in the same cycle. The bench provokes this by pulsing an error event together with a zero write, and by pulsing the seed event on the very edge where `cond_rst` falls. The set must win, which shows as the flag still reading 1 one edge later. The fourth read of a group falls in the same cycle as the pacing counter's restart. The bench judges this by counting edges from that read to the next data-ready rise and comparing the count with the interval alone.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_FILL = 2'd1,
        PS_FULL = 2'd2
    } pacer_state_e;

    typedef enum logic [0:0] {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_state_e;

    localparam int unsigned STAT_W   = 3;
    localparam int unsigned DRDY_BIT = 0;
    localparam int unsigned SEED_BIT = 1;
    localparam int unsigned CLK_BIT  = 2;
endpackage

// File: rtl/rng_flag.sv
module rng_flag
    import rng_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    flag_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FL_CLEAR: if (set_i)           state_nx = FL_SET;
            FL_SET:   if (clr_i && !set_i) state_nx = FL_CLEAR;
            default:                       state_nx = FL_CLEAR;
        endcase
    end

    always_comb q_o = (state == FL_SET);

    // R8: a set pulse always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R5: with neither set nor clear, the flag holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/rng_pacer.sv
module rng_pacer
    import rng_irq_pkg::*;
#(
    parameter int unsigned N_MULT       = 2,
    parameter int unsigned A_NOISE_BASE = 128,
    parameter int unsigned COND_BASE    = 206,
    parameter int unsigned B_NOISE      = 32,
    parameter int unsigned WORDS        = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic cfg_b_i,
    input  logic cond_lim_i,
    input  logic rd_i,
    output logic full_o
);
    localparam int unsigned LIM_A_NOISE = A_NOISE_BASE * N_MULT;
    localparam int unsigned LIM_A_COND  = COND_BASE * N_MULT;
    localparam int unsigned LIM_B_NOISE = B_NOISE;
    localparam int unsigned LIM_B_COND  = COND_BASE;
    localparam int unsigned LIM_MAX1 = (LIM_A_NOISE > LIM_A_COND) ? LIM_A_NOISE : LIM_A_COND;
    localparam int unsigned LIM_MAX2 = (LIM_B_NOISE > LIM_B_COND) ? LIM_B_NOISE : LIM_B_COND;
    localparam int unsigned LIM_MAX  = (LIM_MAX1 > LIM_MAX2) ? LIM_MAX1 : LIM_MAX2;
    localparam int unsigned CNT_W    = $clog2(LIM_MAX + 1);
    localparam int unsigned RD_W     = (WORDS > 2) ? $clog2(WORDS) : 1;

    pacer_state_e      state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [RD_W-1:0]   rd_cnt;
    logic              expire;
    logic              last_rd;

    always_comb begin
        unique case ({cfg_b_i, cond_lim_i})
            2'b00:   lim = CNT_W'(LIM_A_NOISE);
            2'b01:   lim = CNT_W'(LIM_A_COND);
            2'b10:   lim = CNT_W'(LIM_B_NOISE);
            default: lim = CNT_W'(LIM_B_COND);
        endcase
    end

    assign expire  = (state == PS_FILL) && (cnt >= lim - CNT_W'(1));
    assign last_rd = (state == PS_FULL) && rd_i && (rd_cnt == RD_W'(WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!run_i) begin
            state_nx = PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE: state_nx = PS_FILL;
                PS_FILL: if (expire)  state_nx = PS_FULL;
                PS_FULL: if (last_rd) state_nx = PS_FILL;
                default: state_nx = PS_IDLE;
            endcase
        end
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rd_cnt <= '0;
        end else if (!run_i || state != state_nx) begin
            cnt    <= '0;
            rd_cnt <= '0;
        end else if (state == PS_FILL) begin
            cnt <= cnt + CNT_W'(1);
        end else if (state == PS_FULL && rd_i) begin
            rd_cnt <= rd_cnt + RD_W'(1);
        end
    end

    // outputs
    always_comb full_o = (state == PS_FULL);

    a_r9_full_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> ($past(state) == PS_FILL));
    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_FILL) |-> (cnt < lim));
    a_r10_off_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !full_o);
    a_r4_reads_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_FULL) |-> (rd_cnt == '0));
endmodule

// File: rtl/rng_irq_status.sv
module rng_irq_status
    import rng_irq_pkg::*;
#(
    parameter int unsigned N_MULT       = 2,
    parameter int unsigned A_NOISE_BASE = 128,
    parameter int unsigned COND_BASE    = 206,
    parameter int unsigned B_NOISE      = 32,
    parameter int unsigned WORDS        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              irq_en,
    input  logic              cfg_b,
    input  logic              cond_lim,
    input  logic              cond_rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              seed_err_evt,
    input  logic              clk_err_evt,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic cond_q;
    logic cond_fall;
    logic seed_clr, clk_clr;
    logic drdy, seed_f, clk_f;
    logic unused_drdy_wr;

    assign unused_drdy_wr = wr_data[DRDY_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond_rst;
    end

    assign cond_fall = cond_q && !cond_rst;
    assign seed_clr  = (wr_en && !wr_data[SEED_BIT]) || cond_fall;
    assign clk_clr   = wr_en && !wr_data[CLK_BIT];

    rng_pacer #(
        .N_MULT      (N_MULT),
        .A_NOISE_BASE(A_NOISE_BASE),
        .COND_BASE   (COND_BASE),
        .B_NOISE     (B_NOISE),
        .WORDS       (WORDS)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gen_en),
        .cfg_b_i   (cfg_b),
        .cond_lim_i(cond_lim),
        .rd_i      (rd_stb),
        .full_o    (drdy)
    );

    rng_flag u_seed (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(seed_err_evt),
        .clr_i(seed_clr),
        .q_o  (seed_f)
    );

    rng_flag u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(clk_err_evt),
        .clr_i(clk_clr),
        .q_o  (clk_f)
    );

    always_comb begin
        status           = '0;
        status[DRDY_BIT] = drdy;
        status[SEED_BIT] = seed_f;
        status[CLK_BIT]  = clk_f;
        irq              = gen_en && irq_en && (|status);
    end

    a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gen_en && irq_en));
    a_r4_drdy_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status[DRDY_BIT] && gen_en && !rd_stb) |=> status[DRDY_BIT]);
    a_r6_cond_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_q && !cond_rst && !seed_err_evt) |=> !status[SEED_BIT]);
    a_r7_clk_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CLK_BIT] && !wr_en) |=> status[CLK_BIT]);
endmodule

// File: tb/rng_irq_status_bench.sv
module rng_irq_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 0, irq_en = 0, cfg_b = 0, cond_lim = 0, cond_rst = 0;
    logic wr_en = 0, rd_stb = 0, seed_err_evt = 0, clk_err_evt = 0;
    logic [2:0] wr_data = '0;
    logic [2:0] status;
    logic irq;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rng_irq_status u_rng_irq_status (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .irq_en(irq_en),
        .cfg_b(cfg_b), .cond_lim(cond_lim), .cond_rst(cond_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_stb(rd_stb),
        .seed_err_evt(seed_err_evt), .clk_err_evt(clk_err_evt),
        .status(status), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int interval(input bit b, input bit c);
        if (!b) return c ? 206 * 2 : 128 * 2;
        return c ? 206 : 32;
    endfunction

    task automatic count_to_drdy(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!status[0] && n < 1000);
    endtask

    task automatic set_errors();
        seed_err_evt = 1; clk_err_evt = 1;
        step();
        seed_err_evt = 0; clk_err_evt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        check(status == 3'b000, "R1 reset status", status, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        rst_n = 1;
        step();

        // R9 / R4 / R3 sweep of all four interval selections
        for (int m = 0; m < 4; m++) begin
            gen_en = 0; irq_en = 0;
            cfg_b = m[1]; cond_lim = m[0];
            step();
            gen_en = 1;
            count_to_drdy(n);
            check(n == interval(cfg_b, cond_lim) + 1, "R9 first interval", n, interval(cfg_b, cond_lim) + 1);
            check(irq == 0, "R3 irq masked by irq_en", irq, 0);
            irq_en = 1; #1;
            check(irq == 1, "R3 irq on drdy", irq, 1);
            wr_en = 1; wr_data = 3'b000;
            step();
            wr_en = 0;
            check(status[0] == 1, "R4 write leaves drdy", status[0], 1);
            for (int r = 0; r < 4; r++) begin
                rd_stb = 1;
                step();
                rd_stb = 0;
                check(status[0] == (r < 3), "R4 read drain", status[0], (r < 3));
            end
            // reads while empty are ignored: two strobes now, count continues
            n = 0;
            rd_stb = 1; step(); n++; step(); n++;
            rd_stb = 0;
            while (!status[0] && n < 1000) begin step(); n++; end
            check(n == interval(cfg_b, cond_lim), "R9 refill interval", n, interval(cfg_b, cond_lim));
            for (int r = 0; r < 3; r++) begin rd_stb = 1; step(); end
            rd_stb = 0;
            check(status[0] == 1, "R4 early reads ignored", status[0], 1);
            gen_en = 0;
            step();
            check(status[0] == 0, "R10 disable clears drdy", status[0], 0);
            check(irq == 0, "R3 irq low when disabled", irq, 0);
        end

        // R10 restart of the interval
        cfg_b = 1; cond_lim = 0; gen_en = 1;
        repeat (10) step();
        gen_en = 0; step();
        gen_en = 1;
        count_to_drdy(n);
        check(n == 33, "R10 restart interval", n, 33);
        gen_en = 0; step();

        // R2 / R3 error flags
        seed_err_evt = 1; step(); seed_err_evt = 0;
        check(status == 3'b010, "R2 seed set", status, 2);
        check(irq == 0, "R3 irq off with gen_en low", irq, 0);
        clk_err_evt = 1; step(); clk_err_evt = 0;
        check(status == 3'b110, "R2 clock set", status, 6);
        gen_en = 1; #1;
        check(irq == 1, "R3 irq on error", irq, 1);
        irq_en = 0; #1;
        check(irq == 0, "R3 irq_en off", irq, 0);
        gen_en = 0; step();

        // R5 full sweep of write values
        for (int v = 0; v < 8; v++) begin
            set_errors();
            wr_en = 1; wr_data = v[2:0];
            step();
            wr_en = 0;
            check(status == {v[2], v[1], 1'b0}, "R5 write sweep", status, {v[2], v[1], 1'b0});
        end

        // R6 / R7 conditioning reset
        set_errors();
        cond_rst = 1; step();
        check(status[1] == 1, "R6 rise alone keeps seed", status[1], 1);
        cond_rst = 0; step();
        check(status[1] == 0, "R6 fall clears seed", status[1], 0);
        check(status[2] == 1, "R7 clock kept", status[2], 1);

        // R8 collisions
        wr_en = 1; wr_data = 3'b000; seed_err_evt = 1; clk_err_evt = 1;
        step();
        wr_en = 0; seed_err_evt = 0; clk_err_evt = 0;
        check(status == 3'b110, "R8 set beats write clear", status, 6);
        cond_rst = 1; step();
        cond_rst = 0; seed_err_evt = 1; step(); seed_err_evt = 0;
        check(status[1] == 1, "R8 set beats cond fall", status[1], 1);
        wr_en = 1; wr_data = 3'b000; step(); wr_en = 0;
        check(status == 3'b000, "R5 final clear", status, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule